// File: doc/BRIEF.md
# Bus Interface Self-Test Sequencer with Loopback

This block adds a test mode to the control logic of a serial bus interface. While the test input is high, the external receive line is ignored and the block's own transmit line is fed back as the receive signal. The transmit pin keeps working in this mode. The block can join a dedicated test sequence only while the surrounding control machine reports that it is in its start state. The test sequence has two phases.

In the first phase the host strobes `rdy` to swap one byte at a time with the block. Each swap hands back the byte the host supplied in the swap before it, or 0x00 for the first swap after reset. A long strobe carrying 0xFF starts the second phase, which drives a fixed burst onto the transmit line: a 128 µs high mark, a 64 µs low space and a short high glitch. The glitch travels through the loopback and should be caught by the noise detector, which raises the error flag. The data register is cleared at the end of the space. The sequence is left by lowering the test input and pulsing the next-bit request.

States: OFF (normal operation, idle follows the control machine), WAIT (in test, idle low), XFER (strobe high, idle high), MARK, SPACE and GLITCH (burst, idle high). Transitions:
- OFF to WAIT on test high together with start.
- WAIT to XFER on `rdy` high.
- WAIT to OFF on test low together with next request.
- XFER to WAIT when the strobe ends as an ordinary swap.
- XFER to MARK when the strobe ends as a long strobe carrying 0xFF.
- MARK to SPACE, SPACE to GLITCH and GLITCH to WAIT when each segment timer expires.

Top module: `bus_selftest_seq`

## Requirements
- R1: When `test_en` is 1, `bus_rx_int` equals `bus_tx` and `bus_rx_ext` has no effect. When `test_en` is 0, `bus_rx_int` equals `bus_rx_ext`.
- R2: In OFF, WAIT and XFER, `bus_tx` equals `bus_tx_norm`, whatever the value of `test_en`.
- R3: Leaving OFF takes `test_en`=1 and `ctl_at_start`=1 sampled on the same edge. `idle` is 0 from the next cycle on. While in OFF, `idle` equals `idle_norm`.
- R4: In WAIT, `rdy` sampled high moves to XFER, and `idle` is 1 from the next cycle. When `rdy` is sampled low in XFER, the swap completes: `idle` returns to 0 and `ret_byte` is updated in the cycle after.
- R5: The first swap after reset sets `ret_byte` to 0x00. Each later swap sets it to the `host_byte` captured at the end of the swap before. `host_byte` is captured on the edge where `rdy` is first sampled low.
- R6: A strobe is long when `rdy` is sampled high on at least RDY_LONG_CYC edges. Only a long strobe with `host_byte`=0xFF starts the burst. A long strobe with another byte, or a short strobe with 0xFF, is an ordinary swap.
- R7: The burst drives `bus_tx` high for MARK_US, then low for SPACE_US, then high for GLITCH_US microseconds, each lasting CYC_PER_US cycles per µs. `idle` is 1 throughout the burst and 0 right after it.
- R8: The data register is cleared at the end of the space, so the first swap after a burst returns 0x00.
- R9: `err_flag` is set on the edge after a high run of `bus_rx_int` that lasted fewer than FILT_US·CYC_PER_US cycles. A longer run leaves it unchanged. `stat_rd` clears it, and a new set wins over a clear on the same edge.
- R10: WAIT returns to OFF only with `test_en`=0 and `nxt_set`=1. With `test_en` low and no `nxt_set`, the block stays in WAIT with `idle` at 0.
- R11: After reset the block is in OFF, `err_flag` is 0 and `ret_byte` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_en | input | 1 | Test and loopback enable |
| ctl_at_start | input | 1 | Control machine is in its start state |
| nxt_set | input | 1 | Host pulsed the next-bit request |
| rdy | input | 1 | Host ready strobe |
| host_byte | input | BYTE_W | Byte shifted in by the host |
| stat_rd | input | 1 | Status read pulse; clears the error flag |
| bus_rx_ext | input | 1 | External bus receive line |
| bus_tx_norm | input | 1 | Transmit level from the normal symbol generator |
| idle_norm | input | 1 | Idle level from the normal control machine |
| bus_tx | output | 1 | Bus transmit pin |
| bus_rx_int | output | 1 | Receive signal as seen by the receiver |
| idle | output | 1 | Idle indication to the host |
| ret_byte | output | BYTE_W | Byte returned to the host by the last swap |
| err_flag | output | 1 | Noise error status bit |

## Verification
A wrong state shows at the ports within one cycle: `idle` or `bus_tx` take the wrong level, or `bus_rx_int` stops tracking the selected source. A corrupted data register or strobe-length count stays hidden until the end of the next swap, when `ret_byte` takes a wrong value or a burst fails to start. A burst segment of the wrong length shows as a shifted edge on `bus_tx` and a late fall of `idle`. If the glitch is too long or the loopback path is broken, `err_flag` stays clear after the burst. For these reasons the bench compares all outputs against a behavioural model on every clock.

// File: rtl/stq_pkg.sv
package stq_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT,
        ST_XFER,
        ST_MARK,
        ST_SPACE,
        ST_GLITCH
    } stq_state_e;

    function automatic int stq_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/stq_loop_mux.sv
module stq_loop_mux (
    input  logic test_en,
    input  logic rx_ext,
    input  logic tx_loop,
    output logic rx_int
);
    always_comb begin
        rx_int = test_en ? tx_loop : rx_ext;
    end
endmodule

// File: rtl/stq_glitch_det.sv
module stq_glitch_det #(
    parameter int FILT_CYC = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx,
    input  logic stat_rd,
    output logic err
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] FILT_V = CW'(FILT_CYC);

    logic          rx_q;
    logic [CW-1:0] run_cnt;
    logic          short_end;

    assign short_end = rx_q && !rx && (run_cnt < FILT_V);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q    <= 1'b0;
            run_cnt <= '0;
            err     <= 1'b0;
        end else begin
            rx_q <= rx;
            if (rx) begin
                if (!rx_q)                run_cnt <= CW'(1);
                else if (run_cnt != FILT_V) run_cnt <= run_cnt + CW'(1);
            end
            if (short_end)    err <= 1'b1;
            else if (stat_rd) err <= 1'b0;
        end
    end

    AST_LONG_RUN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q && !rx && run_cnt >= FILT_V && !err) |=> !err); // R9
    AST_SHORT_RUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        short_end |=> err); // R9
endmodule

// File: rtl/stq_seq_fsm.sv
module stq_seq_fsm
    import stq_pkg::*;
#(
    parameter int BYTE_W       = 8,
    parameter int MARK_CYC     = 1024,
    parameter int SPACE_CYC    = 512,
    parameter int GLITCH_CYC   = 24,
    parameter int RDY_LONG_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              at_start,
    input  logic              nxt_set,
    input  logic              rdy,
    input  logic [BYTE_W-1:0] host_byte,
    input  logic              tx_norm,
    input  logic              idle_norm,
    output logic              tx,
    output logic              idle,
    output logic [BYTE_W-1:0] ret_byte
);
    localparam int TMAX = stq_max3(MARK_CYC, SPACE_CYC, GLITCH_CYC);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int RW   = $clog2(RDY_LONG_CYC + 1);
    localparam logic [RW-1:0] LONG_V = RW'(RDY_LONG_CYC);

    stq_state_e        state, state_d;
    logic [TW-1:0]     tmr;
    logic [TW-1:0]     seg_last;
    logic              tmr_done;
    logic [RW-1:0]     rcnt;
    logic              is_long;
    logic [BYTE_W-1:0] data_q;

    assign is_long  = (rcnt >= LONG_V);
    assign tmr_done = (tmr == seg_last);

    always_comb begin
        unique case (state)
            ST_MARK:   seg_last = TW'(MARK_CYC - 1);
            ST_SPACE:  seg_last = TW'(SPACE_CYC - 1);
            ST_GLITCH: seg_last = TW'(GLITCH_CYC - 1);
            default:   seg_last = '0;
        endcase
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_OFF:    if (test_en && at_start) state_d = ST_WAIT;
            ST_WAIT: begin
                if (rdy)                     state_d = ST_XFER;
                else if (!test_en && nxt_set) state_d = ST_OFF;
            end
            ST_XFER: begin
                if (!rdy) state_d = (is_long && host_byte == '1) ? ST_MARK : ST_WAIT;
            end
            ST_MARK:   if (tmr_done) state_d = ST_SPACE;
            ST_SPACE:  if (tmr_done) state_d = ST_GLITCH;
            ST_GLITCH: if (tmr_done) state_d = ST_WAIT;
            default:   state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            tmr      <= '0;
            rcnt     <= '0;
            data_q   <= '0;
            ret_byte <= '0;
        end else begin
            state <= state_d;
            if (state != state_d) tmr <= '0;
            else                  tmr <= tmr + TW'(1);
            if (state == ST_WAIT) rcnt <= RW'(1);
            else if (state == ST_XFER && rdy && !is_long) rcnt <= rcnt + RW'(1);
            if (state == ST_XFER && !rdy) begin
                ret_byte <= data_q;
                data_q   <= host_byte;
            end else if (state == ST_SPACE && tmr_done) begin
                data_q   <= '0;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_MARK, ST_GLITCH: tx = 1'b1;
            ST_SPACE:           tx = 1'b0;
            default:            tx = tx_norm;
        endcase
        unique case (state)
            ST_OFF:  idle = idle_norm;
            ST_WAIT: idle = 1'b0;
            default: idle = 1'b1;
        endcase
    end

    AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !(test_en && at_start)) |=> state == ST_OFF); // R3
    AST_ORDINARY_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && !rdy && host_byte != '1) |=> state == ST_WAIT); // R6
    AST_MARK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_MARK |=> state inside {ST_MARK, ST_SPACE}); // R7
    AST_SPACE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SPACE |=> state inside {ST_SPACE, ST_GLITCH}); // R7
    AST_GLITCH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_GLITCH |=> state inside {ST_GLITCH, ST_WAIT}); // R7
    AST_DATA_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_GLITCH |-> data_q == '0); // R8
    AST_NO_EXIT_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && test_en) |=> state != ST_OFF); // R10
endmodule

// File: rtl/bus_selftest_seq.sv
module bus_selftest_seq #(
    parameter int BYTE_W       = 8,
    parameter int CYC_PER_US   = 8,
    parameter int MARK_US      = 128,
    parameter int SPACE_US     = 64,
    parameter int GLITCH_US    = 3,
    parameter int FILT_US      = 7,
    parameter int RDY_LONG_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_en,
    input  logic              ctl_at_start,
    input  logic              nxt_set,
    input  logic              rdy,
    input  logic [BYTE_W-1:0] host_byte,
    input  logic              stat_rd,
    input  logic              bus_rx_ext,
    input  logic              bus_tx_norm,
    input  logic              idle_norm,
    output logic              bus_tx,
    output logic              bus_rx_int,
    output logic              idle,
    output logic [BYTE_W-1:0] ret_byte,
    output logic              err_flag
);
    localparam int MARK_CYC   = MARK_US * CYC_PER_US;
    localparam int SPACE_CYC  = SPACE_US * CYC_PER_US;
    localparam int GLITCH_CYC = GLITCH_US * CYC_PER_US;
    localparam int FILT_CYC   = FILT_US * CYC_PER_US;

    stq_seq_fsm #(
        .BYTE_W(BYTE_W), .MARK_CYC(MARK_CYC), .SPACE_CYC(SPACE_CYC),
        .GLITCH_CYC(GLITCH_CYC), .RDY_LONG_CYC(RDY_LONG_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .at_start(ctl_at_start),
        .nxt_set(nxt_set), .rdy(rdy), .host_byte(host_byte),
        .tx_norm(bus_tx_norm), .idle_norm(idle_norm),
        .tx(bus_tx), .idle(idle), .ret_byte(ret_byte)
    );

    stq_loop_mux u_mux (
        .test_en(test_en), .rx_ext(bus_rx_ext), .tx_loop(bus_tx), .rx_int(bus_rx_int)
    );

    stq_glitch_det #(.FILT_CYC(FILT_CYC)) u_det (
        .clk(clk), .rst_n(rst_n), .rx(bus_rx_int), .stat_rd(stat_rd), .err(err_flag)
    );
endmodule

// File: tb/tb_bus_selftest_seq.sv
module tb_bus_selftest_seq;
    localparam int CPU    = 8;
    localparam int MARK   = 128 * CPU;
    localparam int SPACE  = 64 * CPU;
    localparam int GLITCH = 3 * CPU;
    localparam int FILT   = 7 * CPU;
    localparam int LONG   = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic test_en = 0, ctl_at_start = 0, nxt_set = 0, rdy = 0, stat_rd = 0;
    logic bus_rx_ext = 0, bus_tx_norm = 0, idle_norm = 1;
    logic [7:0] host_byte = 8'h00;
    logic bus_tx, bus_rx_int, idle, err_flag;
    logic [7:0] ret_byte;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;
    string cur_tag = "R11";

    always #4 clk = ~clk;

    bus_selftest_seq #(.BYTE_W(8), .CYC_PER_US(CPU), .MARK_US(128), .SPACE_US(64),
        .GLITCH_US(3), .FILT_US(7), .RDY_LONG_CYC(LONG)) dut (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .ctl_at_start(ctl_at_start),
        .nxt_set(nxt_set), .rdy(rdy), .host_byte(host_byte), .stat_rd(stat_rd),
        .bus_rx_ext(bus_rx_ext), .bus_tx_norm(bus_tx_norm), .idle_norm(idle_norm),
        .bus_tx(bus_tx), .bus_rx_int(bus_rx_int), .idle(idle), .ret_byte(ret_byte),
        .err_flag(err_flag));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // behavioural reference: 0 off, 1 wait, 2 swap, 3 burst
    int m_mode = 0, m_width = 0, hi_run = 0, popped = 0;
    bit prev_rx = 0, m_err = 0;
    logic [7:0] m_data = 0, m_ret = 0;
    bit burst_q[$];

    function automatic bit m_tx();
        if (m_mode == 3 && burst_q.size() > 0) return burst_q[0];
        return bus_tx_norm;
    endfunction
    function automatic bit m_rx();
        return test_en ? m_tx() : bus_rx_ext;
    endfunction
    function automatic bit m_idle();
        if (m_mode == 0) return idle_norm;
        return (m_mode == 1) ? 1'b0 : 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_err = 0; m_data = 0; m_ret = 0; prev_rx = 0; hi_run = 0;
            burst_q.delete();
        end else begin
            bit r, setv;
            r = m_rx();
            setv = 0;
            if (r) hi_run = prev_rx ? hi_run + 1 : 1;
            else if (prev_rx && hi_run < FILT) setv = 1;
            if (setv) m_err = 1; else if (stat_rd) m_err = 0;
            prev_rx = r;
            case (m_mode)
                0: if (test_en && ctl_at_start) m_mode = 1;
                1: begin
                    if (rdy) begin m_mode = 2; m_width = 1; end
                    else if (!test_en && nxt_set) m_mode = 0;
                end
                2: begin
                    if (rdy) m_width++;
                    else begin
                        m_ret = m_data;
                        m_data = host_byte;
                        if (m_width >= LONG && host_byte == 8'hFF) begin
                            m_mode = 3; popped = 0;
                            for (int i = 0; i < MARK; i++) burst_q.push_back(1'b1);
                            for (int i = 0; i < SPACE; i++) burst_q.push_back(1'b0);
                            for (int i = 0; i < GLITCH; i++) burst_q.push_back(1'b1);
                        end else m_mode = 1;
                    end
                end
                default: begin
                    void'(burst_q.pop_front());
                    popped++;
                    if (popped == MARK + SPACE) m_data = 8'h00;
                    if (burst_q.size() == 0) m_mode = 1;
                end
            endcase
        end
        #2;
        if (rst_n && !done) begin
            chk({cur_tag, " bus_tx"}, bus_tx, m_tx());
            chk({cur_tag, " bus_rx_int R1"}, bus_rx_int, m_rx());
            chk({cur_tag, " idle"}, idle, m_idle());
            chk({cur_tag, " ret_byte"}, ret_byte, m_ret);
            chk({cur_tag, " err_flag"}, err_flag, m_err);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input logic [7:0] b, input int n);
        @(negedge clk);
        rdy = 1; host_byte = b;
        cyc(n);
        rdy = 0;
        cyc(2);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                failures++;
                $display("FAIL watchdog expired, actual=hung expected=finish");
                done = 1;
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        cyc(3);
        chk("R11 idle at reset", idle, 1);
        chk("R11 err_flag at reset", err_flag, 0);
        chk("R11 ret_byte at reset", ret_byte, 8'h00);
        rst_n = 1;
        cyc(2);
        // R1 and R2 in normal mode
        cur_tag = "R1";
        bus_rx_ext = 1; cyc(80); chk("R1 ext passes when test low", bus_rx_int, 1);
        bus_rx_ext = 0; cyc(2);
        cur_tag = "R2";
        bus_tx_norm = 1; cyc(3); chk("R2 tx follows normal source", bus_tx, 1);
        bus_tx_norm = 0; cyc(2);
        // R3: test high without start
        cur_tag = "R3";
        test_en = 1; bus_rx_ext = 1; cyc(10);
        chk("R3 no entry without start", idle, 1);
        idle_norm = 0; cyc(1); chk("R3 idle follows normal when off", idle, 0);
        idle_norm = 1; bus_rx_ext = 0;
        ctl_at_start = 1; cyc(1); ctl_at_start = 0; cyc(1);
        chk("R3 idle low after entry", idle, 0);
        // R4 R5 R6 swaps
        cur_tag = "R5";
        @(negedge clk); rdy = 1; host_byte = 8'hA5; cyc(1);
        chk("R4 idle high during swap", idle, 1);
        cyc(3); rdy = 0; cyc(1);
        chk("R4 idle low after swap", idle, 0);
        chk("R5 first swap returns 00", ret_byte, 8'h00);
        cyc(1);
        strobe(8'h3C, 4); chk("R5 echo of previous byte", ret_byte, 8'hA5);
        cur_tag = "R6";
        strobe(8'h5A, 20); chk("R6 long non-FF is ordinary", ret_byte, 8'h3C);
        chk("R6 long non-FF no burst", idle, 0);
        strobe(8'hFF, 4); chk("R6 short FF is ordinary", ret_byte, 8'h5A);
        chk("R6 short FF no burst", idle, 0);
        // R7 burst
        cur_tag = "R7";
        strobe(8'hFF, 20);
        chk("R7 mark drives high", bus_tx, 1);
        chk("R7 idle high in burst", idle, 1);
        chk("R1 loopback in burst", bus_rx_int, 1);
        cyc(MARK);
        chk("R7 space drives low", bus_tx, 0);
        cyc(SPACE + GLITCH + 2);
        chk("R7 idle low after burst", idle, 0);
        chk("R9 glitch sets error", err_flag, 1);
        chk("R5 long FF swap echoed", ret_byte, 8'hFF);
        cur_tag = "R8";
        strobe(8'h11, 4); chk("R8 cleared register returns 00", ret_byte, 8'h00);
        // R9 clear, long run, short run via loopback
        cur_tag = "R9";
        @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
        chk("R9 status read clears", err_flag, 0);
        bus_tx_norm = 1; cyc(FILT + 10); bus_tx_norm = 0; cyc(2);
        chk("R9 long run leaves clear", err_flag, 0);
        bus_tx_norm = 1; cyc(10); bus_tx_norm = 0; cyc(2);
        chk("R9 short run sets", err_flag, 1);
        @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
        // R10 exit
        cur_tag = "R10";
        test_en = 0; bus_rx_ext = 1; cyc(80);
        chk("R10 stays in sequence without next", idle, 0);
        chk("R1 ext restored when test low", bus_rx_int, 1);
        bus_rx_ext = 0;
        nxt_set = 1; cyc(1); nxt_set = 0; cyc(1);
        chk("R10 exit restores normal idle", idle, 1);
        cur_tag = "R9";
        bus_rx_ext = 1; cyc(5); bus_rx_ext = 0; cyc(2);
        chk("R9 glitch on external line sets", err_flag, 1);
        cyc(3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule